// File: doc/BRIEF.md
# Peripheral Access Guard

This block stands between one bus master port and a bank of peripheral slots. It registers each request and checks it in the next cycle against the protection settings of the chosen peripheral. A request carries a master number, a peripheral index, a direction (read or write) and a privilege flag (supervisor or user). The guard then does one of two things. It drives a one-hot select and a strobe to that peripheral and returns its read data. Or it returns an error response and leaves the peripheral untouched.

Every peripheral has three protection bits: a supervisor gate, a write lock and a trust gate. Every master has a privilege-enable bit and a trusted bit. Software sets all of these through a small word-wide register port. The peripherals answer with zero wait states. Requests may arrive every cycle, and each one gets exactly one response.

Top module: `periph_guard`

## Requirements
- R1: Peripheral k is controlled by a 4-bit field in configuration word 1 + k/8. The field's least significant bit is at bit 28 - 4*(k mod 8), so slot 0 of a word sits at bits 31..28. Within the field, bit 3 is reserved, bit 2 is the supervisor gate, bit 1 is the write lock and bit 0 is the trust gate. The reserved bit always reads 0, and writes to it are ignored.
- R2: Master m is controlled from configuration word 0: bit 2m is its trusted flag and bit 2m+1 is its privilege enable. All other bits of word 0 read 0 and ignore writes. Configuration addresses above the last control word read 0.
- R3: After a synchronous reset, every protection bit is 0 and every master is trusted with its privilege enable set. With 4 masters, word 0 reads 0x000000FF. No response is pending.
- R4: A request is sampled on a rising edge while req_valid is high. In the cycle that follows, resp_valid is high for one cycle. If the access is allowed, in that same cycle per_sel has exactly the peripheral's bit set and per_stb is high. per_write, per_addr and per_wdata carry the request. For a read, resp_rdata is that slot's per_rdata (bits k*DATA_W upward); for a write it is 0.
- R5: If the supervisor gate is set, the access fails unless the request is supervisor and the requesting master's privilege enable is 1.
- R6: If the write lock is set, a write fails, while a read still succeeds.
- R7: If the trust gate is set, an access from a master whose trusted flag is 0 fails. The same master may still reach peripherals whose trust gate is 0.
- R8: A failed access raises resp_err together with resp_valid, returns resp_rdata 0, and raises neither per_stb nor any per_sel bit.
- R9: With all three protection bits 0, every access succeeds, whatever the master, direction or privilege.
- R10: A configuration write in the same cycle as a decision does not change that decision. The new setting applies to requests decided in later cycles.
- R11: Requests on consecutive cycles are each answered in order, one response per cycle, each checked against its own attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| req_master | input | MID_W | Requesting master number |
| req_periph | input | PIDX_W | Target peripheral index |
| req_addr | input | ADDR_W | Offset inside the peripheral |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response for the request sampled one cycle earlier |
| resp_err | output | 1 | Access refused |
| resp_rdata | output | DATA_W | Read data; 0 on error or write |
| per_sel | output | NUM_PERIPH | One-hot peripheral select |
| per_stb | output | 1 | Peripheral access strobe |
| per_write | output | 1 | Peripheral access direction |
| per_addr | output | ADDR_W | Peripheral offset |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | NUM_PERIPH*DATA_W | Read data of all slots, slot k at bits k*DATA_W upward |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |

## Verification
A configuration write and a protection decision can fall in the same cycle. The decision uses the stored bits, so the write's effect must wait one cycle. The bench issues a user read to an open peripheral and then, in the very cycle the guard decides on it, writes a word that sets that peripheral's supervisor gate. The first read must still succeed, and an identical read issued after the write must be refused. The scoreboard computes every expected outcome from its own copy of the configuration as it stood when the request was issued, so a design that let the write act early is caught.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;

    localparam int CFG_W          = 32;
    localparam int NIB_W          = 4;
    localparam int SLOTS_PER_WORD = CFG_W / NIB_W;
    localparam int MATTR_W        = 2;
    localparam logic [CFG_W-1:0] RESV_MASK = 32'h8888_8888;

    // protection bits of one peripheral
    typedef struct packed {
        logic sup;
        logic wrp;
        logic trp;
    } guard_t;

    // attributes of one master: bit 1 privilege enable, bit 0 trusted
    typedef struct packed {
        logic priv_en;
        logic trusted;
    } mattr_t;

    // which gate refused an access
    typedef struct packed {
        logic sup;
        logic wrp;
        logic trp;
    } deny_t;

    // lsb of a peripheral field; lower slots sit at higher bits
    function automatic int slot_lsb(input int slot);
        return CFG_W - NIB_W * (slot + 1);
    endfunction

    // configuration word holding a peripheral; word 0 is the master word
    function automatic int word_addr(input int periph);
        return 1 + periph / SLOTS_PER_WORD;
    endfunction

    function automatic logic [NIB_W-1:0] nib_pack(input guard_t g);
        return {1'b0, g.sup, g.wrp, g.trp};
    endfunction

    function automatic guard_t nib_unpack(input logic [NIB_W-1:0] n);
        guard_t g;
        g.sup = n[2];
        g.wrp = n[1];
        g.trp = n[0];
        return g;
    endfunction

    function automatic mattr_t mattr_reset();
        mattr_t a;
        a.priv_en = 1'b1;
        a.trusted = 1'b1;
        return a;
    endfunction

endpackage

// File: rtl/prot_cfg_regs.sv
`timescale 1ns/1ps
module prot_cfg_regs
    import prot_pkg::*;
#(
    parameter int NUM_PERIPH  = 16,
    parameter int NUM_MASTERS = 4,
    parameter int CFG_AW      = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    output guard_t [NUM_PERIPH-1:0]  guard_o,
    output mattr_t [NUM_MASTERS-1:0] mattr_o
);

    localparam logic [CFG_AW-1:0] MASTER_ADDR = '0;

    guard_t [NUM_PERIPH-1:0]  guard_q;
    mattr_t [NUM_MASTERS-1:0] mattr_q;
    logic                     unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_q <= '0;
            for (int m = 0; m < NUM_MASTERS; m++) begin
                mattr_q[m] <= mattr_reset();
            end
        end else if (cfg_we) begin
            for (int k = 0; k < NUM_PERIPH; k++) begin
                if (int'(cfg_addr) == word_addr(k)) begin
                    guard_q[k] <= nib_unpack(cfg_wdata[slot_lsb(k % SLOTS_PER_WORD) +: NIB_W]);
                end
            end
            if (cfg_addr == MASTER_ADDR) begin
                for (int m = 0; m < NUM_MASTERS; m++) begin
                    mattr_q[m] <= mattr_t'(cfg_wdata[MATTR_W*m +: MATTR_W]);
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == MASTER_ADDR) begin
            for (int m = 0; m < NUM_MASTERS; m++) begin
                cfg_rdata[MATTR_W*m +: MATTR_W] = mattr_q[m];
            end
        end
        for (int k = 0; k < NUM_PERIPH; k++) begin
            if (int'(cfg_addr) == word_addr(k)) begin
                cfg_rdata[slot_lsb(k % SLOTS_PER_WORD) +: NIB_W] = nib_pack(guard_q[k]);
            end
        end
    end

    assign guard_o = guard_q;
    assign mattr_o = mattr_q;

    // R1: reserved positions of peripheral words never read back as 1
    assert_resv_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr != MASTER_ADDR) |-> ((cfg_rdata & RESV_MASK) == '0));

    // R2: a master-word write lands in master 0's attributes next cycle
    assert_master_wr_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == MASTER_ADDR) |=> (mattr_o[0] == $past(cfg_wdata[MATTR_W-1:0])));

endmodule

// File: rtl/prot_decide.sv
`timescale 1ns/1ps
module prot_decide
    import prot_pkg::*;
#(
    parameter int NUM_PERIPH  = 16,
    parameter int NUM_MASTERS = 4,
    parameter int PIDX_W      = 4,
    parameter int MID_W       = 2
) (
    input  logic                     valid,
    input  logic                     write,
    input  logic                     priv,
    input  logic [MID_W-1:0]         master,
    input  logic [PIDX_W-1:0]        periph,
    input  guard_t [NUM_PERIPH-1:0]  guard_i,
    input  mattr_t [NUM_MASTERS-1:0] mattr_i,
    output logic                     grant,
    output logic                     deny
);

    guard_t g;
    mattr_t a;
    deny_t  cause;

    always_comb begin
        g         = guard_i[periph];
        a         = mattr_i[master];
        cause.sup = g.sup & ~(priv & a.priv_en);
        cause.wrp = g.wrp & write;
        cause.trp = g.trp & ~a.trusted;
        deny      = valid & (cause != '0);
        grant     = valid & (cause == '0);
    end

endmodule

// File: rtl/prot_periph_port.sv
`timescale 1ns/1ps
module prot_periph_port #(
    parameter int NUM_PERIPH = 16,
    parameter int PIDX_W     = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                         go,
    input  logic [PIDX_W-1:0]            periph,
    input  logic                         write,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_PERIPH*DATA_W-1:0] per_rdata,
    output logic [NUM_PERIPH-1:0]        per_sel,
    output logic                         per_stb,
    output logic                         per_write,
    output logic [ADDR_W-1:0]            per_addr,
    output logic [DATA_W-1:0]            per_wdata,
    output logic [DATA_W-1:0]            rd_data
);

    for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_sel
        assign per_sel[k] = go && (periph == PIDX_W'(k));
    end

    assign per_stb   = go;
    assign per_write = go & write;
    assign per_addr  = go ? addr  : '0;
    assign per_wdata = go ? wdata : '0;
    assign rd_data   = per_rdata[int'(periph)*DATA_W +: DATA_W];

endmodule

// File: rtl/periph_guard.sv
`timescale 1ns/1ps
module periph_guard
    import prot_pkg::*;
#(
    parameter int NUM_PERIPH  = 16,
    parameter int NUM_MASTERS = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    localparam int PIDX_W     = $clog2(NUM_PERIPH),
    localparam int MID_W      = $clog2(NUM_MASTERS),
    localparam int CTRL_WORDS = (NUM_PERIPH + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD,
    localparam int CFG_AW     = $clog2(CTRL_WORDS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_priv,
    input  logic [MID_W-1:0]             req_master,
    input  logic [PIDX_W-1:0]            req_periph,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         resp_valid,
    output logic                         resp_err,
    output logic [DATA_W-1:0]            resp_rdata,
    output logic [NUM_PERIPH-1:0]        per_sel,
    output logic                         per_stb,
    output logic                         per_write,
    output logic [ADDR_W-1:0]            per_addr,
    output logic [DATA_W-1:0]            per_wdata,
    input  logic [NUM_PERIPH*DATA_W-1:0] per_rdata,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [CFG_W-1:0]             cfg_wdata,
    output logic [CFG_W-1:0]             cfg_rdata
);

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              sup;
        logic [MID_W-1:0]  master;
        logic [PIDX_W-1:0] periph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } stage_t;

    stage_t                   stage_q;
    guard_t [NUM_PERIPH-1:0]  guard_w;
    mattr_t [NUM_MASTERS-1:0] mattr_w;
    logic                     grant;
    logic                     deny;
    logic [DATA_W-1:0]        rd_data;

    // request stage: the decision is taken on these registers
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= req_valid;
            if (req_valid) begin
                stage_q.write  <= req_write;
                stage_q.sup    <= req_priv;
                stage_q.master <= req_master;
                stage_q.periph <= req_periph;
                stage_q.addr   <= req_addr;
                stage_q.wdata  <= req_wdata;
            end
        end
    end

    prot_cfg_regs #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_MASTERS(NUM_MASTERS),
        .CFG_AW     (CFG_AW)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .guard_o  (guard_w),
        .mattr_o  (mattr_w)
    );

    prot_decide #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_MASTERS(NUM_MASTERS),
        .PIDX_W     (PIDX_W),
        .MID_W      (MID_W)
    ) u_decide (
        .valid  (stage_q.valid),
        .write  (stage_q.write),
        .priv   (stage_q.sup),
        .master (stage_q.master),
        .periph (stage_q.periph),
        .guard_i(guard_w),
        .mattr_i(mattr_w),
        .grant  (grant),
        .deny   (deny)
    );

    prot_periph_port #(
        .NUM_PERIPH(NUM_PERIPH),
        .PIDX_W    (PIDX_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_port (
        .go       (grant),
        .periph   (stage_q.periph),
        .write    (stage_q.write),
        .addr     (stage_q.addr),
        .wdata    (stage_q.wdata),
        .per_rdata(per_rdata),
        .per_sel  (per_sel),
        .per_stb  (per_stb),
        .per_write(per_write),
        .per_addr (per_addr),
        .per_wdata(per_wdata),
        .rd_data  (rd_data)
    );

    assign resp_valid = stage_q.valid;
    assign resp_err   = deny;
    assign resp_rdata = (grant && !stage_q.write) ? rd_data : '0;

    // R4: every response answers a request sampled one edge earlier
    assert_resp_timing_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid));

    // R4: at most one peripheral is selected
    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(per_sel));

    // R5: a user access to a supervisor-gated slot is refused
    assert_sup_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && guard_w[stage_q.periph].sup && !stage_q.sup) |-> resp_err);

    // R6: a write to a locked slot is refused
    assert_wp_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && guard_w[stage_q.periph].wrp && stage_q.write) |-> resp_err);

    // R7: an untrusted master is refused by a trust-gated slot
    assert_trust_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && guard_w[stage_q.periph].trp && !mattr_w[stage_q.master].trusted) |-> resp_err);

    // R8: a refused access never reaches a peripheral and returns no data
    assert_deny_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (per_sel == '0 && !per_stb && resp_rdata == '0));

    // R9: an unprotected slot is always reached
    assert_open_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && guard_w[stage_q.periph] == '0) |-> (!resp_err && per_stb));

endmodule

// File: tb/periph_guard_tb.sv
`timescale 1ns/1ps
module periph_guard_tb;

    localparam int NP  = 16;
    localparam int NM  = 4;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int PW  = 4;
    localparam int MW  = 2;
    localparam int CAW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_priv = 1'b0;
    logic [MW-1:0]     req_master = '0;
    logic [PW-1:0]     req_periph = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              resp_valid;
    logic              resp_err;
    logic [DW-1:0]     resp_rdata;
    logic [NP-1:0]     per_sel;
    logic              per_stb;
    logic              per_write;
    logic [AW-1:0]     per_addr;
    logic [DW-1:0]     per_wdata;
    logic [NP*DW-1:0]  per_rdata;
    logic              cfg_we = 1'b0;
    logic [CAW-1:0]    cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;

    typedef struct {
        logic          err;
        logic [DW-1:0] rdata;
        int            periph;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        string         tag;
    } exp_t;

    exp_t        exp_q[$];
    int          total = 0;
    int          fails = 0;
    logic [31:0] sh_m;
    logic [31:0] sh_c [1:2];

    always #5 clk = ~clk;

    periph_guard #(
        .NUM_PERIPH (NP),
        .NUM_MASTERS(NM),
        .ADDR_W     (AW),
        .DATA_W     (DW)
    ) u_dut (.*);

    function automatic logic [DW-1:0] rd_pat(input int p);
        return 32'hA500_0000 | (p << 8) | p;
    endfunction

    always_comb begin
        for (int k = 0; k < NP; k++) begin
            per_rdata[k*DW +: DW] = rd_pat(k);
        end
    end

    function automatic logic [2:0] nib(input int p);
        return sh_c[1 + p / 8][(28 - 4 * (p % 8)) +: 3];
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: one request per call, expectation from the shadow copy
    task automatic send(input int m, input int p, input logic wr, input logic pv,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        exp_t        e;
        logic [2:0]  n;
        logic        fail;
        n    = nib(p);
        fail = (n[2] && !(pv && sh_m[2*m+1])) || (n[1] && wr) || (n[0] && !sh_m[2*m]);
        e.err    = fail;
        e.rdata  = (!fail && !wr) ? rd_pat(p) : '0;
        e.periph = p;
        e.write  = wr;
        e.addr   = a;
        e.wdata  = wd;
        e.tag    = tag;
        exp_q.push_back(e);
        req_valid  = 1'b1;
        req_write  = wr;
        req_priv   = pv;
        req_master = MW'(m);
        req_periph = PW'(p);
        req_addr   = a;
        req_wdata  = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = CAW'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) sh_m = d & 32'h0000_00FF;
        else if (a <= 2) sh_c[a] = d & 32'h7777_7777;
    endtask

    task automatic cfg_chk(input int a, input logic [31:0] expv, input string tag);
        cfg_addr = CAW'(a);
        #2;
        chk(cfg_rdata == expv, tag, cfg_rdata, expv);
        @(negedge clk);
    endtask

    // monitor: pops one expectation per response
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 response without request", 32'(resp_valid), 32'h0);
            end else begin
                exp_t          e;
                logic [NP-1:0] es;
                bit            ok;
                e  = exp_q.pop_front();
                es = '0;
                if (!e.err) es[e.periph] = 1'b1;
                ok = (resp_err == e.err) && (resp_rdata == e.rdata) && (per_sel == es) &&
                     (per_stb == !e.err) &&
                     (e.err || (per_write == e.write && per_addr == e.addr && per_wdata == e.wdata));
                total++;
                if (!ok) begin
                    fails++;
                    $display("FAIL %s actual err=%0b rdata=%h sel=%h stb=%0b expected err=%0b rdata=%h sel=%h stb=%0b",
                             e.tag, resp_err, resp_rdata, per_sel, per_stb, e.err, e.rdata, es, !e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        sh_m    = 32'h0000_00FF;
        sh_c[1] = '0;
        sh_c[2] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset state
        chk(resp_valid == 1'b0, "R3 no response after reset", 32'(resp_valid), 32'h0);
        cfg_chk(0, 32'h0000_00FF, "R3 master word reset");
        cfg_chk(1, 32'h0, "R3 word 1 reset");
        cfg_chk(2, 32'h0, "R3 word 2 reset");
        cfg_chk(3, 32'h0, "R2 unused address reads 0");

        // R9 open access
        send(1, 3, 1'b0, 1'b0, 8'h10, 32'h0, "R9 open user read");
        send(2, 15, 1'b1, 1'b0, 8'h22, 32'hDEAD_BEEF, "R9 open user write");
        idle();

        // R1 layout and reserved bits
        cfg_wr(1, 32'hFFFF_FFFF);
        cfg_chk(1, 32'h7777_7777, "R1 reserved bits read 0");
        cfg_wr(1, 32'h0000_4000);
        cfg_chk(1, 32'h0000_4000, "R1 slot 4 supervisor gate");

        // R5 supervisor gate on slot 4
        send(0, 4, 1'b0, 1'b0, 8'h04, 32'h0, "R5 user refused");
        send(0, 4, 1'b0, 1'b1, 8'h05, 32'h0, "R5 supervisor with enable");
        idle();
        cfg_wr(0, 32'h0000_00FD);
        send(0, 4, 1'b0, 1'b1, 8'h06, 32'h0, "R5 supervisor without enable");
        send(1, 4, 1'b1, 1'b1, 8'h07, 32'h1234_5678, "R5 other master enabled");
        idle();
        cfg_chk(0, 32'h0000_00FD, "R2 master word readback");
        cfg_wr(0, 32'hFFFF_FFFF);
        cfg_chk(0, 32'h0000_00FF, "R2 upper master bits read 0");

        // R6 write lock on slot 9, R7 trust gate on slot 13
        cfg_wr(2, 32'h0200_0100);
        cfg_chk(2, 32'h0200_0100, "R1 word 2 layout");
        send(3, 9, 1'b0, 1'b0, 8'h30, 32'h0, "R6 read of locked slot");
        send(3, 9, 1'b1, 1'b0, 8'h31, 32'hCAFE_0001, "R6 write to locked slot");
        idle();
        cfg_wr(0, 32'h0000_00EF);
        send(2, 13, 1'b0, 1'b1, 8'h40, 32'h0, "R7 untrusted master refused");
        send(3, 13, 1'b1, 1'b0, 8'h41, 32'h0BAD_F00D, "R7 trusted master allowed");
        send(2, 9, 1'b0, 1'b0, 8'h42, 32'h0, "R7 untrusted to ungated slot");
        idle();

        // R10 configuration write in the decision cycle
        send(1, 7, 1'b0, 1'b0, 8'h50, 32'h0, "R10 decision uses old setting");
        idle();
        cfg_wr(1, 32'h0000_4004);
        send(1, 7, 1'b0, 1'b0, 8'h51, 32'h0, "R10 new setting applies later");
        idle();

        // R11 back-to-back mix
        send(0, 0, 1'b1, 1'b0, 8'h60, 32'h1111_0000, "R11 burst open write");
        send(2, 13, 1'b1, 1'b0, 8'h61, 32'h2222_0000, "R11 burst untrusted");
        send(1, 9, 1'b0, 1'b0, 8'h62, 32'h0, "R11 burst locked read");
        send(1, 9, 1'b1, 1'b1, 8'h63, 32'h4444_0000, "R11 burst locked write");
        send(3, 4, 1'b0, 1'b1, 8'h64, 32'h0, "R11 burst supervisor read");
        idle();

        @(negedge clk);
        chk(resp_valid == 1'b0, "R4 response lasts one cycle", 32'(resp_valid), 32'h0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all responses delivered", 32'(exp_q.size()), 32'h0);
        report();
    end

endmodule